// File: doc/BRIEF.md
# Indirect Channel Setting Access Slave

This block is a memory-mapped slave that holds a small table of per-channel analog settings: a drive-level value and a pre-tap value, with room for four features on each of eight logical channels. The host does not address the table directly. It loads a channel number register, a feature offset register and, for an update, a data register. It then writes a command bit into a control/status register. The block takes the operands at that moment, stays busy for a fixed number of cycles, and then either commits the data into the table or copies the stored value back into the data register.

Software polls the busy flag before it starts an access and again before it uses a result. A command that names a channel or feature outside the table raises an error flag and leaves the table and the data register alone. The bus is a plain single-cycle register port with no back-pressure: each write takes effect at the clock edge where it is presented, and read data appears on the cycle after the read strobe.

Top module: `chan_cfg_slave`

## Requirements
- R1: Word address 0x8 holds the channel number, 0xB the feature offset and 0xC the data word. The channel and offset registers keep the low 8 bits of the written data and read back zero-extended. The data register keeps all 32 bits. Any address other than these and 0xA reads as 0. Read data is presented on `rdata_o` one cycle after `rd_i` is sampled high.
- R2: In the control/status register at 0xA, writing bit 0 high issues a write command and writing bit 1 high issues a read command. Both bits always read back 0. Bit 8 reads as the busy flag and bit 9 as the error flag; all other bits read 0.
- R3: An accepted command makes busy read 1 on each of the 4 cycles after the command write, and 0 on the fifth.
- R4: A write command stores the low 6 bits of the captured data word into the selected entry (feature 0 is the drive level and feature 1 is the pre-tap) when busy clears.
- R5: A read command loads the selected entry, zero-extended to 32 bits, into the data register when busy clears. If the host writes the data register on that same edge, the loaded value wins.
- R6: A command written while busy is 1 is ignored. The channel, offset and data values are captured when a command is accepted, so register writes made during busy do not affect that command.
- R7: If the captured channel is 8 or more, or the captured offset is 4 or more, the error flag is set when busy clears, and neither the table nor the data register changes. A command with channel and offset in range clears the error flag when busy clears.
- R8: A command write with both bit 0 and bit 1 high acts as a write command only.
- R9: Reset clears every table entry, the three operand registers, busy and error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | 4 | Word address |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read strobe |

## Verification
A wrong busy counter shows up at the first control/status poll after a command: busy is seen high for too many or too few cycles, or a command sent during the window is wrongly taken. A wrongly captured operand, or a wrong table index, shows up only when that entry is later fetched back through the data register. So the bench fills every entry with a distinct value and reads every entry back. Error-path faults show up at bit 9 on the poll that sees busy clear, and in data register contents that should have stayed untouched.

// File: rtl/chan_cfg_pkg.sv
package chan_cfg_pkg;
  // Word addresses of the host-visible registers.
  localparam logic [3:0] A_CHAN = 4'h8;
  localparam logic [3:0] A_CSR  = 4'hA;
  localparam logic [3:0] A_OFFS = 4'hB;
  localparam logic [3:0] A_DATA = 4'hC;

  // Control/status bit positions.
  localparam int CSR_WR_BIT   = 0;
  localparam int CSR_RD_BIT   = 1;
  localparam int CSR_BUSY_BIT = 8;
  localparam int CSR_ERR_BIT  = 9;

  // Feature offsets with an analog meaning.
  localparam int FEAT_DRIVE  = 0;
  localparam int FEAT_PRETAP = 1;

  typedef struct packed {
    logic wr;
    logic rd;
  } cmd_t;
endpackage

// File: rtl/chan_cfg_store.sv
module chan_cfg_store #(
  parameter int DEPTH = 32,
  parameter int SET_W = 6,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [AW-1:0]    idx_i,
  input  logic [SET_W-1:0] wdata_i,
  output logic [SET_W-1:0] rdata_o
);
  logic [SET_W-1:0] ent [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        ent[g] <= '0;
      else if (we_i && (idx_i == AW'(g)))
        ent[g] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < DEPTH; i++)
      if (idx_i == AW'(i)) rdata_o = ent[i];
  end
endmodule

// File: rtl/chan_cfg_regs.sv
module chan_cfg_regs
  import chan_cfg_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              busy_i,
  input  logic              err_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_val_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [IDX_W-1:0]  ch_o,
  output logic [IDX_W-1:0]  off_o,
  output logic [DATA_W-1:0] data_o,
  output cmd_t              cmd_o
);
  logic [IDX_W-1:0]  ch_q, off_q;
  logic [DATA_W-1:0] data_q, rmux, rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch_q   <= '0;
      off_q  <= '0;
      data_q <= '0;
    end else begin
      if (wr_i && addr_i == A_CHAN) ch_q  <= wdata_i[IDX_W-1:0];
      if (wr_i && addr_i == A_OFFS) off_q <= wdata_i[IDX_W-1:0];
      // A completing fetch takes priority over a host write (R5).
      if (load_i)
        data_q <= load_val_i;
      else if (wr_i && addr_i == A_DATA)
        data_q <= wdata_i;
    end
  end

  // Command bits are pulses only; they are never stored (R2).
  always_comb begin
    cmd_o.wr = wr_i && (addr_i == A_CSR) && wdata_i[CSR_WR_BIT];
    cmd_o.rd = wr_i && (addr_i == A_CSR) && wdata_i[CSR_RD_BIT] && !wdata_i[CSR_WR_BIT];
  end

  always_comb begin
    rmux = '0;
    unique case (addr_i)
      A_CHAN: rmux = DATA_W'(ch_q);
      A_OFFS: rmux = DATA_W'(off_q);
      A_DATA: rmux = data_q;
      A_CSR: begin
        rmux[CSR_BUSY_BIT] = busy_i;
        rmux[CSR_ERR_BIT]  = err_i;
      end
      default: rmux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rdata_q <= '0;
    else if (rd_i) rdata_q <= rmux;
  end

  assign rdata_o = rdata_q;
  assign ch_o    = ch_q;
  assign off_o   = off_q;
  assign data_o  = data_q;

  a_r5_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (data_q == $past(load_val_i)));

  a_r8_single_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_o.wr && cmd_o.rd));
endmodule

// File: rtl/chan_cfg_seq.sv
module chan_cfg_seq
  import chan_cfg_pkg::*;
#(
  parameter int NUM_CH   = 8,
  parameter int NUM_FEAT = 4,
  parameter int SET_W    = 6,
  parameter int IDX_W    = 8,
  parameter int DATA_W   = 32,
  parameter int BUSY_CYC = 4,
  localparam int DEPTH = NUM_CH * NUM_FEAT,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(BUSY_CYC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cmd_t              cmd_i,
  input  logic [IDX_W-1:0]  ch_i,
  input  logic [IDX_W-1:0]  off_i,
  input  logic [SET_W-1:0]  data_i,
  input  logic [SET_W-1:0]  st_rdata_i,
  output logic              st_we_o,
  output logic [AW-1:0]     st_idx_o,
  output logic [SET_W-1:0]  st_wdata_o,
  output logic              load_o,
  output logic [DATA_W-1:0] load_val_o,
  output logic              busy_o,
  output logic              err_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             cap_wr_q, err_q;
  logic [IDX_W-1:0] cap_ch_q, cap_off_q;
  logic [SET_W-1:0] cap_dat_q;
  logic             accept, done, in_rng;
  int unsigned      lin;

  assign busy_o = (cnt_q != '0);
  assign accept = (cmd_i.wr || cmd_i.rd) && !busy_o;
  assign done   = (cnt_q == CNT_W'(1));

  always_comb begin
    in_rng = (int'(cap_ch_q) < NUM_CH) && (int'(cap_off_q) < NUM_FEAT);
    lin    = int'(cap_ch_q) * NUM_FEAT + int'(cap_off_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      cap_wr_q  <= 1'b0;
      cap_ch_q  <= '0;
      cap_off_q <= '0;
      cap_dat_q <= '0;
      err_q     <= 1'b0;
    end else begin
      if (accept) begin
        cnt_q     <= CNT_W'(BUSY_CYC);
        cap_wr_q  <= cmd_i.wr;
        cap_ch_q  <= ch_i;
        cap_off_q <= off_i;
        cap_dat_q <= data_i;
      end else if (busy_o) begin
        cnt_q <= cnt_q - CNT_W'(1);
      end
      if (done) err_q <= !in_rng;
    end
  end

  assign st_idx_o   = in_rng ? AW'(lin) : '0;
  assign st_wdata_o = cap_dat_q;
  assign st_we_o    = done && cap_wr_q && in_rng;
  assign load_o     = done && !cap_wr_q && in_rng;
  assign load_val_o = DATA_W'(st_rdata_i);
  assign err_o      = err_q;

  a_r3_busy_starts: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy_o);

  a_r3_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done) |=> busy_o);

  a_r6_ignore_busy: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_i.wr || cmd_i.rd) && busy_o) |=> ($stable(cap_ch_q) && $stable(cap_off_q) && $stable(cap_dat_q)));

  a_r7_err_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(err_q) |-> $fell(busy_o));

  a_r4_store_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    st_we_o |=> !busy_o);
endmodule

// File: rtl/chan_cfg_slave.sv
module chan_cfg_slave
  import chan_cfg_pkg::*;
#(
  parameter int NUM_CH   = 8,
  parameter int NUM_FEAT = 4,
  parameter int SET_W    = 6,
  parameter int IDX_W    = 8,
  parameter int DATA_W   = 32,
  parameter int BUSY_CYC = 4,
  localparam int DEPTH = NUM_CH * NUM_FEAT,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  cmd_t              cmd;
  logic [IDX_W-1:0]  ch, off;
  logic [DATA_W-1:0] data, load_val;
  logic              busy, err, load, st_we;
  logic [AW-1:0]     st_idx;
  logic [SET_W-1:0]  st_wdata, st_rdata;

  chan_cfg_regs #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .wr_i(wr_i), .rd_i(rd_i),
    .wdata_i(wdata_i), .busy_i(busy), .err_i(err), .load_i(load),
    .load_val_i(load_val), .rdata_o(rdata_o), .ch_o(ch), .off_o(off),
    .data_o(data), .cmd_o(cmd)
  );

  chan_cfg_seq #(
    .NUM_CH(NUM_CH), .NUM_FEAT(NUM_FEAT), .SET_W(SET_W), .IDX_W(IDX_W),
    .DATA_W(DATA_W), .BUSY_CYC(BUSY_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_i(cmd), .ch_i(ch), .off_i(off),
    .data_i(data[SET_W-1:0]), .st_rdata_i(st_rdata), .st_we_o(st_we),
    .st_idx_o(st_idx), .st_wdata_o(st_wdata), .load_o(load),
    .load_val_o(load_val), .busy_o(busy), .err_o(err)
  );

  chan_cfg_store #(.DEPTH(DEPTH), .SET_W(SET_W)) u_store (
    .clk(clk), .rst_n(rst_n), .we_i(st_we), .idx_i(st_idx),
    .wdata_i(st_wdata), .rdata_o(st_rdata)
  );

  // Upper data bits are kept for readback only.
  logic unused_hi;
  assign unused_hi = ^data[DATA_W-1:SET_W];
endmodule

// File: tb/tb_chan_cfg_slave.sv
module tb_chan_cfg_slave;
  localparam int NCH = 8, NFT = 4, NENT = NCH * NFT;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  chan_cfg_slave dut (.clk(clk), .rst_n(rst_n), .addr_i(addr), .wr_i(wr),
                      .rd_i(rd), .wdata_i(wdata), .rdata_o(rdata));

  always #5 clk = ~clk;

  int vectors = 0, miscompares = 0;
  bit finished = 0;

  // Behavioural reference model, advanced on every rising edge.
  int          m_mem [NENT];
  int          m_ch, m_off, m_cnt, m_pch, m_poff;
  logic [31:0] m_dat, m_pdat, exp_rd;
  bit          m_err, m_pwr;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_mem[i]) m_mem[i] = 0;
      m_ch = 0; m_off = 0; m_dat = 0; m_cnt = 0; m_err = 0; exp_rd = 0;
    end else begin
      automatic bit b = (m_cnt != 0);
      if (rd) begin
        case (addr)
          4'h8: exp_rd = m_ch;
          4'hB: exp_rd = m_off;
          4'hC: exp_rd = m_dat;
          4'hA: exp_rd = (32'(b) << 8) | (32'(m_err) << 9);
          default: exp_rd = 0;
        endcase
      end
      if (wr && addr == 4'h8) m_ch  = wdata[7:0];
      if (wr && addr == 4'hB) m_off = wdata[7:0];
      if (wr && addr == 4'hC) m_dat = wdata;
      if (b) begin
        m_cnt--;
        if (m_cnt == 0) begin
          if (m_pch < NCH && m_poff < NFT) begin
            m_err = 0;
            if (m_pwr) m_mem[m_pch*NFT+m_poff] = m_pdat & 32'h3F;
            else       m_dat = m_mem[m_pch*NFT+m_poff];
          end else m_err = 1;
        end
      end
      if (wr && addr == 4'hA && !b && (wdata[0] || wdata[1])) begin
        m_cnt = 4; m_pwr = wdata[0]; m_pch = m_ch; m_poff = m_off; m_pdat = m_dat;
      end
    end
  end

  task automatic op(input string tag, input bit r, input bit w,
                    input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    rd = r; wr = w; addr = a; wdata = d;
    @(posedge clk); #1;
    if (r) begin
      vectors++;
      if (rdata !== exp_rd) begin
        miscompares++;
        $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, rdata, exp_rd);
      end
    end
    rd = 0; wr = 0;
  endtask

  task automatic rdreg(input string tag, input logic [3:0] a);
    op(tag, 1, 0, a, 0);
  endtask

  task automatic wrreg(input logic [3:0] a, input logic [31:0] d);
    op("wr", 0, 1, a, d);
  endtask

  task automatic poll(input string tag);
    for (int k = 0; k < 20; k++) begin
      rdreg(tag, 4'hA);
      if (rdata[8] == 1'b0) break;
    end
  endtask

  task automatic do_write(input int ch, input int off, input logic [31:0] d);
    wrreg(4'h8, ch); wrreg(4'hB, off); wrreg(4'hC, d); wrreg(4'hA, 32'h1);
    poll("R4 poll");
  endtask

  task automatic do_read(input string tag, input int ch, input int off);
    wrreg(4'h8, ch); wrreg(4'hB, off); wrreg(4'hA, 32'h2);
    poll("R5 poll");
    rdreg(tag, 4'hC);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R9: reset state
    rdreg("R9 chan", 4'h8); rdreg("R9 offs", 4'hB);
    rdreg("R9 data", 4'hC); rdreg("R9 csr", 4'hA);
    // R1: operand registers and unused addresses
    wrreg(4'h8, 32'hFFFF_FF05); rdreg("R1 chan", 4'h8);
    wrreg(4'hB, 32'h0000_0103); rdreg("R1 offs", 4'hB);
    wrreg(4'hC, 32'hDEAD_BEEF); rdreg("R1 data", 4'hC);
    rdreg("R1 unused", 4'h0); rdreg("R1 unused", 4'hF); rdreg("R1 unused", 4'h9);
    // R2/R3: busy window and self-clearing command bits
    wrreg(4'hA, 32'h1);
    for (int k = 0; k < 6; k++) rdreg("R3 busy window", 4'hA);
    // R4/R5: fill all entries with distinct values (bits above 5 dropped)
    for (int i = 0; i < NENT; i++)
      do_write(i / NFT, i % NFT, 32'hA5A5_A5C0 | ((i * 7 + 3) & 63));
    for (int i = 0; i < NENT; i++)
      do_read("R5 readback", i / NFT, i % NFT);
    // R6: command during busy ignored, operand changes during busy ignored
    wrreg(4'h8, 2); wrreg(4'hB, 1); wrreg(4'hC, 32'h11); wrreg(4'hA, 32'h1);
    wrreg(4'h8, 3); wrreg(4'hC, 32'h22); wrreg(4'hA, 32'h1);
    poll("R6 poll");
    do_read("R6 captured", 2, 1);
    do_read("R6 not taken", 3, 1);
    // R5: fetch result wins over a same-edge host data write
    wrreg(4'h8, 2); wrreg(4'hB, 1); wrreg(4'hA, 32'h2);
    wrreg(4'h0, 0); wrreg(4'h0, 0); wrreg(4'h0, 0);
    wrreg(4'hC, 32'h3333_3333);
    rdreg("R5 load wins", 4'hC);
    // R7: out of range channel, then offset; error cleared by a good command
    wrreg(4'hC, 32'h77); wrreg(4'h8, 8); wrreg(4'hB, 0); wrreg(4'hA, 32'h2);
    poll("R7 err chan"); rdreg("R7 data kept", 4'hC);
    wrreg(4'h8, 0); wrreg(4'hB, 4); wrreg(4'hA, 32'h1);
    poll("R7 err offs");
    do_read("R7 table kept", 0, 0);
    rdreg("R7 err cleared", 4'hA);
    // R8: both command bits -> write
    wrreg(4'h8, 5); wrreg(4'hB, 2); wrreg(4'hC, 32'h2A); wrreg(4'hA, 32'h3);
    poll("R8 poll");
    wrreg(4'hC, 0);
    do_read("R8 write taken", 5, 2);
    // R9: reset mid-operation clears table
    wrreg(4'h8, 1); wrreg(4'hB, 0); wrreg(4'hC, 32'h3F); wrreg(4'hA, 32'h1);
    @(negedge clk); rst_n = 0;
    @(posedge clk); @(negedge clk); rst_n = 1;
    rdreg("R9 csr after reset", 4'hA);
    do_read("R9 table cleared", 5, 2);
    do_read("R9 table cleared", 1, 0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule